// File: doc/BRIEF.md
# Nibble-Packed Audio Delay Line Controller

This block turns a nibble-wide external memory into a circular delay buffer for one audio channel. A 32-cycle frame counter marks each sample period. At the start of every frame the block pulses a sample-and-hold strobe and accepts one 12-bit converted sample. Later in the same frame it reads back, from three consecutive 4-bit words, the sample that lies the selected delay behind the write point. It then stores the new sample as three nibbles, lowest nibble first, and moves the write point on by three words.

A 3-bit range select picks one of six fixed delays, from 2 ms up to about one second at a 42.66 kHz sample rate. After reset, and whenever the effective range changes, two mute lines of opposite polarity are held for 256 sample periods. During that time the output word is forced to mid-scale.

The sample input uses a valid/ready pair. Ready is high only in the first cycle of each frame, and a sample is taken when valid is also high in that cycle. The source is never stalled for longer than one frame. If no valid sample arrives in that slot, the block stores the last accepted sample again. The output side has no back-pressure: the consumer must take the word in the single cycle that out_valid is high.

Top module: `nibble_delay_line`

## Requirements
- R1: The frame is 32 cycles long. sh_strobe and in_ready are both high in frame position 0 and low in every other position. in_data is taken only when in_valid is high in position 0. If it is not, the previously taken sample is written again. The sample held after reset is 0x800.
- R2: In positions 6, 7 and 8 the block writes (mem_we = 1) nibbles [3:0], [7:4] and [11:8] of the taken sample to word addresses W, W+1 and W+2. W is 0 after reset and grows by 3 each frame, wrapping from 131049 back to 0 (buffer of 131052 words).
- R3: In positions 1, 2 and 3 the block reads (mem_we = 0) words R, R+1 and R+2, where R = (W − 3·D) mod 131052 and D is the delay in samples.
- R4: range_sel values 0 to 5 give D = 85, 341, 1365, 5460, 21842 and 43684 samples. Values 6 and 7 act as value 5.
- R5: out_valid is high for exactly position 5 of each frame. out_data is then {nibble read at position 3, position 2, position 1}, with the position-1 read as the low nibble. When not muted, this is the sample written D frames earlier.
- R6: After reset, mute_sh = 1 and mute_exp_n = 0. Both stay in that state for 256 frames after reset, and for 256 frames after a frame start at which the effective range differs from the one in use. While muted, out_data reads 0x800.
- R7: A change of range_sel between codes with the same effective range (5, 6 and 7) does not start a mute.
- R8: Word address bit 16 drives mem_bank and bits 15:0 drive mem_addr. Words 0 to 65535 are in bank 0.
- R9: The memory returns read data one cycle after the address. A read issued in position p is captured at the end of position p+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 32 cycles per sample |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample on in_data is valid |
| in_ready | output | 1 | Sample slot open (frame position 0) |
| in_data | input | 12 | Converted input sample |
| out_valid | output | 1 | Delayed word present on out_data |
| out_data | output | 12 | Delayed sample, mid-scale while muted |
| range_sel | input | 3 | Delay range code |
| sh_strobe | output | 1 | Sample-and-hold strobe, once per frame |
| mute_sh | output | 1 | Mute for sample-and-hold, active high |
| mute_exp_n | output | 1 | Mute for expander, active low |
| mem_bank | output | 1 | Memory bank select |
| mem_addr | output | 16 | Word address within the bank |
| mem_we | output | 1 | Write enable for the nibble memory |
| mem_wdata | output | 4 | Nibble to write |
| mem_rdata | input | 4 | Nibble read, one cycle after address |

## Verification
The assertions assume that mem_rdata follows the one-cycle read latency and that range_sel changes no more than once per frame. They also assume in_valid and in_data matter only at the frame start. The stimulus changes range_sel just after a clock edge and holds it for many frames. It drives in_valid and in_data with random values in every cycle, so that data offered outside the ready slot would show up as an error. The memory model answers every read exactly one cycle later and returns zero for words never written.

// File: rtl/nbd_pkg.sv
package nbd_pkg;

  // Delay in samples for a range index.
  // Ranges step by x4 from 2 ms, and the last range is twice the one below it.
  // rate_dhz is the sample rate in units of 10 Hz.
  function automatic int range_samples(input int idx, input int n_ranges, input int rate_dhz);
    int ms;
    if (idx >= n_ranges - 1) ms = 2 << (2 * (n_ranges - 2) + 1);
    else                     ms = 2 << (2 * idx);
    return (ms * rate_dhz + 50) / 100;
  endfunction

endpackage

// File: rtl/nbd_frame_seq.sv
module nbd_frame_seq #(
  parameter int FRAME_CYC = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  output logic [$clog2(FRAME_CYC)-1:0] pos,
  output logic                         frame_tick
);
  localparam int PW = $clog2(FRAME_CYC);
  localparam logic [PW-1:0] LAST = PW'(FRAME_CYC - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)           pos <= '0;
    else if (pos == LAST) pos <= '0;
    else                  pos <= pos + 1'b1;
  end

  assign frame_tick = (pos == '0);

  // R1: the frame closes after the last position
  assert_frame_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == LAST) |=> frame_tick);

  // R1: positions advance by one inside a frame
  assert_frame_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pos != LAST) |=> (pos == $past(pos) + 1'b1));
endmodule

// File: rtl/nbd_addr_gen.sv
module nbd_addr_gen #(
  parameter int ADDR_W    = 17,
  parameter int BUF_WORDS = 131052,
  parameter int STEP      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic [ADDR_W-1:0] offset,
  output logic [ADDR_W-1:0] wr_base,
  output logic [ADDR_W-1:0] rd_base
);
  localparam logic [ADDR_W-1:0] BUF_A  = ADDR_W'(BUF_WORDS);
  localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(STEP);

  logic [ADDR_W-1:0] wr_next;

  always_comb begin
    wr_next = wr_base + STEP_A;
    if (wr_next >= BUF_A) wr_next = wr_next - BUF_A;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       wr_base <= '0;
    else if (advance) wr_base <= wr_next;
  end

  // Offset is at most the buffer length, so either branch stays in range
  always_comb begin
    if (wr_base >= offset) rd_base = wr_base - offset;
    else                   rd_base = wr_base + (BUF_A - offset);
  end

  // R2: the write point stays on a sample boundary inside the buffer
  assert_wr_in_buf_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_base < BUF_A) && ((wr_base % STEP_A) == '0));

  // R2: the write point moves only when a frame's writes are done
  assert_wr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(wr_base));

  // R3: the read point is always a legal buffer word
  assert_rd_in_buf_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_base < BUF_A);
endmodule

// File: rtl/nbd_mute_ctl.sv
module nbd_mute_ctl #(
  parameter int SEL_W       = 3,
  parameter int N_RANGES    = 6,
  parameter int MUTE_FRAMES = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_tick,
  input  logic [SEL_W-1:0] sel,
  output logic [SEL_W-1:0] rng_idx,
  output logic             mute_active
);
  localparam int CW = $clog2(MUTE_FRAMES + 1);
  localparam logic [SEL_W-1:0] TOP_SEL = SEL_W'(N_RANGES - 1);
  localparam logic [CW-1:0]    LOAD    = CW'(MUTE_FRAMES);

  logic [SEL_W-1:0] sel_c;
  logic [CW-1:0]    cnt;

  assign sel_c = (sel > TOP_SEL) ? TOP_SEL : sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rng_idx <= '0;
      cnt     <= LOAD;
    end else if (frame_tick) begin
      if (sel_c != rng_idx) begin
        rng_idx <= sel_c;
        cnt     <= LOAD;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign mute_active = (cnt != '0);

  // R6: a new effective range always opens a mute window
  assert_mute_on_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && (sel_c != rng_idx)) |=> mute_active);

  // R6: a mute only ends at a frame start
  assert_mute_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_tick && mute_active) |=> mute_active);

  // R4: the index in use is always one of the defined ranges
  assert_range_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rng_idx <= TOP_SEL);
endmodule

// File: rtl/nibble_delay_line.sv
module nibble_delay_line
  import nbd_pkg::*;
#(
  parameter int FRAME_CYC   = 32,
  parameter int SAMP_W      = 12,
  parameter int NIB_W       = 4,
  parameter int BUF_WORDS   = 131052,
  parameter int MUTE_FRAMES = 256,
  parameter int SEL_W       = 3,
  parameter int N_RANGES    = 6,
  parameter int RATE_DHZ    = 4266
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  output logic                            in_ready,
  input  logic [SAMP_W-1:0]               in_data,
  output logic                            out_valid,
  output logic [SAMP_W-1:0]               out_data,
  input  logic [SEL_W-1:0]                range_sel,
  output logic                            sh_strobe,
  output logic                            mute_sh,
  output logic                            mute_exp_n,
  output logic                            mem_bank,
  output logic [$clog2(BUF_WORDS)-2:0]    mem_addr,
  output logic                            mem_we,
  output logic [NIB_W-1:0]                mem_wdata,
  input  logic [NIB_W-1:0]                mem_rdata
);
  localparam int NIBS     = SAMP_W / NIB_W;
  localparam int NIW      = (NIBS > 1) ? $clog2(NIBS) : 1;
  localparam int ADDR_W   = $clog2(BUF_WORDS);
  localparam int PW       = $clog2(FRAME_CYC);
  localparam int RD_FIRST = 1;
  localparam int RD_LAST  = RD_FIRST + NIBS - 1;
  localparam int OUT_SLOT = RD_LAST + 1;
  localparam int WR_FIRST = OUT_SLOT + 2;
  localparam int WR_LAST  = WR_FIRST + NIBS - 1;
  localparam logic [SAMP_W-1:0] MID   = SAMP_W'(1) << (SAMP_W - 1);
  localparam logic [ADDR_W-1:0] BUF_A = ADDR_W'(BUF_WORDS);

  logic [PW-1:0]     pos;
  logic              frame_tick;
  logic [SEL_W-1:0]  rng_idx;
  logic              mute_active;
  logic [ADDR_W-1:0] wr_base, rd_base, offset, addr_full;
  logic [SAMP_W-1:0] samp_q, word_q, word_in;
  logic [NIB_W-1:0]  samp_nib [NIBS];
  logic [NIB_W-1:0]  rd_nib   [NIBS];
  logic [NIW-1:0]    wr_idx;
  logic              in_rd_win, in_wr_win;

  nbd_frame_seq #(.FRAME_CYC(FRAME_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .pos(pos), .frame_tick(frame_tick)
  );

  nbd_mute_ctl #(.SEL_W(SEL_W), .N_RANGES(N_RANGES), .MUTE_FRAMES(MUTE_FRAMES)) u_mute (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .sel(range_sel),
    .rng_idx(rng_idx), .mute_active(mute_active)
  );

  // Word distance between write and read points: NIBS words per sample of delay
  always_comb begin
    int w;
    w = NIBS * range_samples(int'(rng_idx), N_RANGES, RATE_DHZ);
    if (w > BUF_WORDS) w = BUF_WORDS;
    offset = ADDR_W'(w);
  end

  nbd_addr_gen #(.ADDR_W(ADDR_W), .BUF_WORDS(BUF_WORDS), .STEP(NIBS)) u_addr (
    .clk(clk), .rst_n(rst_n), .advance(pos == PW'(WR_LAST)),
    .offset(offset), .wr_base(wr_base), .rd_base(rd_base)
  );

  // Sample slot at frame start
  assign in_ready  = frame_tick;
  assign sh_strobe = frame_tick;

  always_ff @(posedge clk) begin
    if (!rst_n)                    samp_q <= MID;
    else if (frame_tick && in_valid) samp_q <= in_data;
  end

  // Nibble split of the stored sample, and nibble gather of the read one
  for (genvar i = 0; i < NIBS; i++) begin : g_nib
    assign samp_nib[i] = samp_q[i*NIB_W +: NIB_W];
    if (i < NIBS - 1) begin : g_cap
      always_ff @(posedge clk) begin
        if (!rst_n)                              rd_nib[i] <= '0;
        else if (pos == PW'(RD_FIRST + 1 + i))   rd_nib[i] <= mem_rdata;
      end
    end else begin : g_last
      assign rd_nib[i] = mem_rdata;
    end
    assign word_in[i*NIB_W +: NIB_W] = rd_nib[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q    <= MID;
      out_valid <= 1'b0;
    end else begin
      out_valid <= (pos == PW'(OUT_SLOT));
      if (pos == PW'(OUT_SLOT)) word_q <= word_in;
    end
  end

  assign out_data   = mute_active ? MID : word_q;
  assign mute_sh    = mute_active;
  assign mute_exp_n = !mute_active;

  // Memory slot decode: reads first, then writes
  assign in_rd_win = (pos >= PW'(RD_FIRST)) && (pos <= PW'(RD_LAST));
  assign in_wr_win = (pos >= PW'(WR_FIRST)) && (pos <= PW'(WR_LAST));
  assign wr_idx    = NIW'(pos - PW'(WR_FIRST));

  always_comb begin
    mem_we    = 1'b0;
    mem_wdata = '0;
    addr_full = wr_base;
    if (in_rd_win) begin
      addr_full = rd_base + ADDR_W'(pos - PW'(RD_FIRST));
    end else if (in_wr_win) begin
      mem_we    = 1'b1;
      addr_full = wr_base + ADDR_W'(wr_idx);
      mem_wdata = samp_nib[wr_idx];
    end
  end

  assign mem_bank = addr_full[ADDR_W-1];
  assign mem_addr = addr_full[ADDR_W-2:0];

  // R8: every memory access lands inside the buffer
  assert_addr_in_buf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    {mem_bank, mem_addr} < BUF_A);

  // R1: no memory write in the sample slot
  assert_slot_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sh_strobe |-> !mem_we);

  // R5: output word is a single-cycle pulse
  assert_out_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R6: mid-scale output whenever muted
  assert_mute_midscale_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mute_sh |-> (out_data == MID));
endmodule

// File: tb/nibble_delay_line_test.sv
module nibble_delay_line_test;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME      = 32;
  localparam int BUFW       = 131052;
  localparam int MUTE_N     = 256;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, out_valid;
  logic [11:0] in_data, out_data;
  logic [2:0]  range_sel;
  logic        sh_strobe, mute_sh, mute_exp_n;
  logic        mem_bank, mem_we;
  logic [15:0] mem_addr;
  logic [3:0]  mem_wdata, mem_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  bit running = 1'b0;

  nibble_delay_line uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .range_sel(range_sel), .sh_strobe(sh_strobe), .mute_sh(mute_sh),
    .mute_exp_n(mute_exp_n), .mem_bank(mem_bank), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Nibble memory with one-cycle read latency
  logic [3:0] mem [int];
  always @(posedge clk) begin
    int a;
    a = {15'd0, mem_bank, mem_addr};
    if (mem_we) mem[a] = mem_wdata;
    else        mem_rdata <= mem.exists(a) ? mem[a] : 4'h0;
  end

  function automatic int dly(input int s);
    case (s)
      0: return 85;      1: return 341;     2: return 1365;
      3: return 5460;    4: return 21842;   default: return 43684;
    endcase
  endfunction

  function automatic int eff(input int s);
    return (s > 5) ? 5 : s;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bench model state
  int hist[$];
  int f = -1, pos = 0, cur = 'h800, mprev = 0, mcnt = MUTE_N, d = 85, wp = 0, rexp = 0;

  always @(negedge clk) begin
    if (running) begin
      if (sh_strobe) begin
        if (f >= 0) check(pos == FRAME - 1, "R1 frame length", pos + 1, FRAME);
        pos = 0;
        f++;
        check(in_ready == 1'b1, "R1 ready at slot", in_ready, 1);
        check(mute_sh == (mcnt != 0) && mute_exp_n == (mcnt == 0), "R6 R7 mute lines",
              mute_sh, mcnt != 0);
        in_valid = ($urandom % 4) != 0;
        in_data  = 12'($urandom);
        if (in_valid) cur = in_data;
        hist.push_back(cur);
        if (eff(range_sel) != mprev) begin mprev = eff(range_sel); mcnt = MUTE_N; end
        else if (mcnt > 0) mcnt--;
        d    = dly(mprev);
        wp   = (f * 3) % BUFW;
        rexp = (wp + BUFW - ((3 * d) % BUFW)) % BUFW;
      end else begin
        pos++;
        check(in_ready == 1'b0 && sh_strobe == 1'b0, "R1 slot only at start", in_ready, 0);
        in_valid = 1'($urandom);
        in_data  = 12'($urandom);
      end

      if (pos >= 1 && pos <= 3) begin
        check(!mem_we && {mem_bank, mem_addr} == 17'(rexp + pos - 1), "R3 R4 read address",
              {mem_bank, mem_addr}, rexp + pos - 1);
        if (pos == 1)
          check(mem_bank == (rexp >= 65536) && mem_addr == 16'(rexp), "R8 bank split",
                {mem_bank, mem_addr}, rexp);
      end
      if (pos >= 6 && pos <= 8) begin
        check(mem_we && {mem_bank, mem_addr} == 17'(wp + pos - 6) &&
              mem_wdata == 4'(cur >> (4 * (pos - 6))), "R2 nibble write",
              {mem_we, mem_bank, mem_addr, mem_wdata}, {1'b1, 17'(wp + pos - 6), 4'(cur >> (4 * (pos - 6)))});
      end
      if (pos == 5) begin
        int e;
        if (mcnt != 0)    e = 'h800;
        else if (f >= d)  e = hist[f - d];
        else              e = 0;
        check(out_valid == 1'b1 && out_data == 12'(e), "R5 R6 R9 delayed word", out_data, e);
      end else begin
        check(out_valid == 1'b0, "R5 single pulse", out_valid, 0);
      end
    end
  end

  task automatic run_frames(input int n);
    repeat (n * FRAME) @(posedge clk);
    #1;
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; range_sel = 3'd0; in_valid = 1'b0; in_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Reset state
    check(mute_sh == 1'b1 && mute_exp_n == 1'b0, "R6 reset mute", mute_sh, 1);
    check(out_valid == 1'b0 && mem_we == 1'b0, "R6 reset idle", {out_valid, mem_we}, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    running = 1'b1;
    run_frames(400);   range_sel = 3'd1;
    run_frames(500);   range_sel = 3'd2;
    run_frames(1300);  range_sel = 3'd3;
    run_frames(150);   range_sel = 3'd4;
    run_frames(150);   range_sel = 3'd5;
    run_frames(300);
    check(mute_sh == 1'b0, "R7 unmuted before alias", mute_sh, 0);
    range_sel = 3'd7;
    run_frames(60);
    check(mute_sh == 1'b0 && mute_exp_n == 1'b1, "R7 alias code keeps mute off", mute_sh, 0);
    range_sel = 3'd6;
    run_frames(10);
    check(mute_sh == 1'b0, "R7 second alias code", mute_sh, 0);
    range_sel = 3'd1;
    run_frames(2);
    check(mute_sh == 1'b1 && out_data == 12'h800, "R6 remute on change", out_data, 'h800);
    run_frames(300);
    running = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule